// File: doc/BRIEF.md
# Single-Cycle Word Processor Core

This block is a 32-bit processor that completes one instruction in every clock cycle. It supports word load, word store, branch-if-equal, an absolute jump, and five register-to-register operations: add, subtract, AND, OR and signed set-less-than. The program counter has its own increment adder and its own branch-target adder, so the main ALU is free for the instruction's own work in the same cycle. A two-level decode drives the ALU. The main decoder produces a 2-bit class selector. That selector either forces addition or subtraction, or passes control to the 6-bit function field, which produces a 3-bit operation code.

Instruction memory and data memory are separate and word-addressed. Both are written through a preload port, which is accepted only while reset is high. The program and its initial data are placed there before the core is released. Each store appears on a set of observation outputs in the cycle it executes, and the current program counter is always visible.

Top module: `rc_core`

## Requirements
- R1: While `rst` is high, each rising edge sets the program counter to 0. During reset no store is issued (`st_en_o` low) and no register is written.
- R2: An instruction that is not a taken branch or a jump moves the program counter to PC+4 at the next edge.
- R3: Opcode 0 selects a register operation on rs (bits 25-21) and rt (bits 20-16), written to rd (bits 15-11). Function field (bits 5-0) values: 100000 add, 100010 subtract (rs-rt), 100100 AND, 100101 OR, 101010 signed set-less-than (result 1 or 0).
- R4: Opcode 35 loads the data word at byte address rs + sign-extended bits 15-0 into rt. The next instruction reads the new value.
- R5: Opcode 43 stores rt at byte address rs + sign-extended bits 15-0. In that cycle `st_en_o` is high, `st_addr_o` carries the address and `st_data_o` carries the data. `st_en_o` is low for every other instruction.
- R6: Opcode 4 compares rs and rt by subtraction. When they are equal, the next PC is PC+4 plus the sign-extended bits 15-0 shifted left by two. Otherwise the next PC is PC+4. Negative offsets branch backwards.
- R7: Opcode 2 sets the next PC to the upper 4 bits of PC+4, then bits 25-0 of the instruction, then two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it has no effect.
- R9: While `rst` is high, a `load_we` pulse writes `load_data` into the word at index `load_addr`. The target is instruction memory when `load_sel` is 0 and data memory when `load_sel` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| load_we | input | 1 | Preload write strobe, accepted only in reset |
| load_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | LAW (6) | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter (byte address) |
| st_en_o | output | 1 | A store executes this cycle |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Data word of the store |

## Verification
A fault in the register file, the ALU or the decode cannot be seen directly. It surfaces only when a later store carries a wrong address or wrong data, or when a later branch or jump takes the wrong path. It therefore shows at the ports one instruction or more after the fault. The program counter output gives an immediate view of sequencing: a wrong branch decision or a wrong target shows on `pc_o` in the cycle right after the branch or jump. A fault in the reset or preload gating shows up as a store during reset, or as a program that runs different code or data.

// File: rtl/rc_pkg.sv
package rc_pkg;

  localparam int XLEN = 32;

  // primary opcodes, bits 31-26
  localparam logic [5:0] OPC_REG   = 6'd0;
  localparam logic [5:0] OPC_JUMP  = 6'd2;
  localparam logic [5:0] OPC_BEQ   = 6'd4;
  localparam logic [5:0] OPC_LOAD  = 6'd35;
  localparam logic [5:0] OPC_STORE = 6'd43;

  // function field codes for register operations
  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  // 3-bit operation code seen by the ALU
  typedef enum logic [2:0] {
    ALU_AND = 3'b000,
    ALU_OR  = 3'b001,
    ALU_ADD = 3'b010,
    ALU_SUB = 3'b110,
    ALU_SLT = 3'b111
  } alu_op_e;

  // class selector from the main decoder
  typedef enum logic [1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FUNCT = 2'b10
  } alu_cls_e;

  typedef struct packed {
    logic     dst_is_rd;
    logic     b_is_imm;
    logic     wb_from_mem;
    logic     reg_we;
    logic     mem_we;
    logic     is_branch;
    logic     is_jump;
    alu_cls_e alu_cls;
  } ctrl_t;

endpackage

// File: rtl/rc_regfile.sv
module rc_regfile #(
  parameter int W    = 32,
  parameter int NREG = 32
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(NREG)-1:0] wa,
  input  logic [W-1:0]            wd,
  input  logic [$clog2(NREG)-1:0] ra1,
  input  logic [$clog2(NREG)-1:0] ra2,
  output logic [W-1:0]            rd1,
  output logic [W-1:0]            rd2
);
  localparam int AW = $clog2(NREG);

  logic [W-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (wa != AW'(0))) regs[wa] <= wd;
  end

  assign rd1 = (ra1 == AW'(0)) ? '0 : regs[ra1];
  assign rd2 = (ra2 == AW'(0)) ? '0 : regs[ra2];
endmodule

// File: rtl/rc_alu.sv
module rc_alu #(
  parameter int W = 32
) (
  input  rc_pkg::alu_op_e op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    y,
  output logic            zero
);
  import rc_pkg::*;

  logic [W-1:0] diff;
  assign diff = a - b;

  always_comb begin
    case (op)
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SUB: y = diff;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end

  assign zero = (y == '0);
endmodule

// File: rtl/rc_ctrl.sv
module rc_ctrl (
  input  logic [5:0]      opcode,
  input  logic [5:0]      funct,
  output rc_pkg::ctrl_t   ctl,
  output rc_pkg::alu_op_e alu_op
);
  import rc_pkg::*;

  // first level: instruction class
  always_comb begin
    ctl         = '0;
    ctl.alu_cls = CLS_ADD;
    case (opcode)
      OPC_REG: begin
        ctl.dst_is_rd = 1'b1;
        ctl.reg_we    = 1'b1;
        ctl.alu_cls   = CLS_FUNCT;
      end
      OPC_LOAD: begin
        ctl.b_is_imm    = 1'b1;
        ctl.wb_from_mem = 1'b1;
        ctl.reg_we      = 1'b1;
      end
      OPC_STORE: begin
        ctl.b_is_imm = 1'b1;
        ctl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctl.is_branch = 1'b1;
        ctl.alu_cls   = CLS_SUB;
      end
      OPC_JUMP: ctl.is_jump = 1'b1;
      default: ;
    endcase
  end

  // second level: class plus function field
  always_comb begin
    case (ctl.alu_cls)
      CLS_ADD: alu_op = ALU_ADD;
      CLS_SUB: alu_op = ALU_SUB;
      default: begin
        case (funct)
          FN_SUB:  alu_op = ALU_SUB;
          FN_AND:  alu_op = ALU_AND;
          FN_OR:   alu_op = ALU_OR;
          FN_SLT:  alu_op = ALU_SLT;
          default: alu_op = ALU_ADD;
        endcase
      end
    endcase
  end
endmodule

// File: rtl/rc_wordmem.sv
module rc_wordmem #(
  parameter int W     = 32,
  parameter int DEPTH = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/rc_core.sv
module rc_core #(
  parameter int IMEM_WORDS = 64,
  parameter int DMEM_WORDS = 64,
  parameter int NREG       = 32,
  localparam int IAW = $clog2(IMEM_WORDS),
  localparam int DAW = $clog2(DMEM_WORDS),
  localparam int LAW = (IAW > DAW) ? IAW : DAW
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_we,
  input  logic           load_sel,
  input  logic [LAW-1:0] load_addr,
  input  logic [31:0]    load_data,
  output logic [31:0]    pc_o,
  output logic           st_en_o,
  output logic [31:0]    st_addr_o,
  output logic [31:0]    st_data_o
);
  import rc_pkg::*;

  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] pc_q, pc4, br_tgt, jmp_tgt, pc_next;
  logic [XLEN-1:0] instr, imm_sx;
  logic [XLEN-1:0] rd1, rd2, alu_b, alu_y, dmem_q, wb_data;
  logic            alu_zero;
  ctrl_t           ctl;
  alu_op_e         alu_ctl;
  logic [RAW-1:0]  wr_sel;
  logic            imem_we, dmem_we;
  logic [DAW-1:0]  dmem_waddr;
  logic [XLEN-1:0] dmem_wdata;

  // program counter
  always_ff @(posedge clk) begin
    if (rst) pc_q <= '0;
    else     pc_q <= pc_next;
  end

  assign pc4     = pc_q + XLEN'(4);
  assign imm_sx  = {{(XLEN-16){instr[15]}}, instr[15:0]};
  assign br_tgt  = pc4 + {imm_sx[XLEN-3:0], 2'b00};
  assign jmp_tgt = {pc4[31:28], instr[25:0], 2'b00};

  always_comb begin
    if (ctl.is_jump)                  pc_next = jmp_tgt;
    else if (ctl.is_branch && alu_zero) pc_next = br_tgt;
    else                              pc_next = pc4;
  end

  // instruction memory, written only by the preload port
  assign imem_we = rst & load_we & ~load_sel;

  rc_wordmem #(.W(XLEN), .DEPTH(IMEM_WORDS)) u_imem (
    .clk   (clk),
    .we    (imem_we),
    .waddr (load_addr[IAW-1:0]),
    .wdata (load_data),
    .raddr (pc_q[IAW+1:2]),
    .rdata (instr)
  );

  rc_ctrl u_ctrl (
    .opcode (instr[31:26]),
    .funct  (instr[5:0]),
    .ctl    (ctl),
    .alu_op (alu_ctl)
  );

  assign wr_sel = ctl.dst_is_rd ? instr[15:11] : instr[20:16];

  rc_regfile #(.W(XLEN), .NREG(NREG)) u_rf (
    .clk (clk),
    .we  (ctl.reg_we & ~rst),
    .wa  (wr_sel),
    .wd  (wb_data),
    .ra1 (instr[25:21]),
    .ra2 (instr[20:16]),
    .rd1 (rd1),
    .rd2 (rd2)
  );

  assign alu_b = ctl.b_is_imm ? imm_sx : rd2;

  rc_alu #(.W(XLEN)) u_alu (
    .op   (alu_ctl),
    .a    (rd1),
    .b    (alu_b),
    .y    (alu_y),
    .zero (alu_zero)
  );

  // data memory: preload port in reset, store path otherwise
  assign dmem_we    = rst ? (load_we & load_sel) : ctl.mem_we;
  assign dmem_waddr = rst ? load_addr[DAW-1:0] : alu_y[DAW+1:2];
  assign dmem_wdata = rst ? load_data : rd2;

  rc_wordmem #(.W(XLEN), .DEPTH(DMEM_WORDS)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (dmem_waddr),
    .wdata (dmem_wdata),
    .raddr (alu_y[DAW+1:2]),
    .rdata (dmem_q)
  );

  assign wb_data = ctl.wb_from_mem ? dmem_q : alu_y;

  assign pc_o      = pc_q;
  assign st_en_o   = ctl.mem_we & ~rst;
  assign st_addr_o = alu_y;
  assign st_data_o = rd2;
endmodule

// File: rtl/rc_core_chk.sv
module rc_core_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] pc,
  input logic [31:0] instr,
  input logic [31:0] rd1,
  input logic [31:0] rd2,
  input logic [31:0] alu_y,
  input logic [2:0]  alu_ctl,
  input logic        st_en,
  input logic [31:0] st_addr
);
  logic [5:0]  opc;
  logic [31:0] sx, chk_btgt, chk_jtgt;
  assign opc      = instr[31:26];
  assign sx       = {{16{instr[15]}}, instr[15:0]};
  assign chk_btgt = pc + 32'd4 + {sx[29:0], 2'b00};
  assign chk_jtgt = {pc[31:28] + ((pc[27:0] > 28'hFFFFFFB) ? 4'd1 : 4'd0), instr[25:0], 2'b00};

  assert_pc_reset_R1: assert property (@(posedge clk) rst |=> pc == 32'd0);

  assert_no_store_in_reset_R1: assert property (@(posedge clk) rst |-> !st_en);

  assert_pc_step_R2: assert property (@(posedge clk) disable iff (rst)
    (opc != 6'd4 && opc != 6'd2) |=> pc == $past(pc) + 32'd4);

  assert_slt_result_R3: assert property (@(posedge clk) disable iff (rst)
    (alu_ctl == 3'b111) |-> alu_y == {31'd0, ($signed(rd1) < $signed(rd2))});

  assert_store_addr_R5: assert property (@(posedge clk) disable iff (rst)
    st_en |-> st_addr == rd1 + sx);

  assert_branch_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd4 && rd1 == rd2) |=> pc == $past(chk_btgt));

  assert_branch_not_taken_R6: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd4 && rd1 != rd2) |=> pc == $past(pc) + 32'd4);

  assert_jump_target_R7: assert property (@(posedge clk) disable iff (rst)
    (opc == 6'd2) |=> pc == $past(chk_jtgt));

  assert_reg0_zero_R8: assert property (@(posedge clk) disable iff (rst)
    (instr[25:21] == 5'd0) |-> rd1 == 32'd0);
endmodule

bind rc_core rc_core_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .pc      (pc_q),
  .instr   (instr),
  .rd1     (rd1),
  .rd2     (rd2),
  .alu_y   (alu_y),
  .alu_ctl (alu_ctl),
  .st_en   (st_en_o),
  .st_addr (st_addr_o)
);

// File: tb/tb_rc_core.sv
module tb_rc_core;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int MAXC       = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        load_we = 1'b0;
  logic        load_sel = 1'b0;
  logic [5:0]  load_addr = '0;
  logic [31:0] load_data = '0;
  logic [31:0] pc_o, st_addr_o, st_data_o;
  logic        st_en_o;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  logic [31:0] prog [MAXC];
  int          plen;
  logic [31:0] pc_log [MAXC], sa_log [MAXC], sd_log [MAXC];
  logic        se_log [MAXC];
  logic [31:0] e_pc [MAXC], e_sa [MAXC], e_sd [MAXC];
  logic        e_se [MAXC];
  string       t_pc [MAXC], t_st [MAXC];

  rc_core dut (
    .clk       (clk),
    .rst       (rst),
    .load_we   (load_we),
    .load_sel  (load_sel),
    .load_addr (load_addr),
    .load_data (load_data),
    .pc_o      (pc_o),
    .st_en_o   (st_en_o),
    .st_addr_o (st_addr_o),
    .st_data_o (st_data_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc >= WATCHDOG) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_r(logic [4:0] rs, logic [4:0] rt, logic [4:0] rd, logic [5:0] fn);
    return {6'd0, rs, rt, rd, 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, logic [4:0] rs, logic [4:0] rt, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [25:0] t);
    return {6'd2, t};
  endfunction

  task automatic load_word(input logic sel, input int idx, input logic [31:0] w);
    @(negedge clk);
    load_we   = 1'b1;
    load_sel  = sel;
    load_addr = idx[5:0];
    load_data = w;
  endtask

  task automatic clear_expect(input int n);
    for (int k = 0; k < n; k++) begin
      e_se[k] = 1'b0; e_sa[k] = '0; e_sd[k] = '0;
      t_pc[k] = "R2"; t_st[k] = "R5";
    end
  endtask

  task automatic run_prog(input int n);
    rst = 1'b1;
    for (int i = 0; i < plen; i++) load_word(1'b0, i, prog[i]);
    @(negedge clk);
    load_we = 1'b0;
    @(negedge clk);
    rst = 1'b0;
    #1;
    for (int k = 0; k < n; k++) begin
      if (k > 0) @(negedge clk);
      pc_log[k] = pc_o; se_log[k] = st_en_o;
      sa_log[k] = st_addr_o; sd_log[k] = st_data_o;
    end
  endtask

  task automatic compare(input int n);
    for (int k = 0; k < n; k++) begin
      chk(t_pc[k], pc_log[k], e_pc[k]);
      chk(t_st[k], {31'd0, se_log[k]}, {31'd0, e_se[k]});
      if (e_se[k]) begin
        chk(t_st[k], sa_log[k], e_sa[k]);
        chk(t_st[k], sd_log[k], e_sd[k]);
      end
    end
  endtask

  task automatic expect_store(input int k, input logic [31:0] a, input logic [31:0] d, input string tag);
    e_se[k] = 1'b1; e_sa[k] = a; e_sd[k] = d; t_st[k] = tag;
  endtask

  task automatic preload_data();
    load_word(1'b1, 0, 32'd5);
    load_word(1'b1, 1, 32'd3);
    load_word(1'b1, 2, 32'hFFFF_FFF9);
    load_word(1'b1, 3, 32'h0F0F_00FF);
    load_word(1'b1, 4, 32'h00FF_0FF0);
    @(negedge clk);
    load_we = 1'b0;
  endtask

  // R1: reset holds PC at 0 and suppresses a store at address 0
  task automatic test_reset();
    rst = 1'b1;
    load_word(1'b0, 0, enc_i(6'd43, 5'd0, 5'd0, 16'd0));
    load_word(1'b0, 1, enc_j(26'd0));
    @(negedge clk);
    load_we = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R1 pc in reset", pc_o, 32'd0);
      chk("R1 no store in reset", {31'd0, st_en_o}, 32'd0);
    end
  endtask

  // R3 R4 R8 R9: register operations, loads with offsets, register 0
  task automatic test_alu();
    plen = 22;
    prog[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    prog[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    prog[2]  = enc_i(6'd35, 5'd0, 5'd3, 16'd8);
    prog[3]  = enc_i(6'd35, 5'd0, 5'd7, 16'd12);
    prog[4]  = enc_i(6'd35, 5'd0, 5'd8, 16'd16);
    prog[5]  = enc_r(5'd1, 5'd2, 5'd4, 6'b100000);
    prog[6]  = enc_i(6'd43, 5'd0, 5'd4, 16'd128);
    prog[7]  = enc_r(5'd2, 5'd1, 5'd5, 6'b100010);
    prog[8]  = enc_i(6'd43, 5'd0, 5'd5, 16'd132);
    prog[9]  = enc_r(5'd7, 5'd8, 5'd6, 6'b100100);
    prog[10] = enc_i(6'd43, 5'd0, 5'd6, 16'd136);
    prog[11] = enc_r(5'd7, 5'd8, 5'd6, 6'b100101);
    prog[12] = enc_i(6'd43, 5'd0, 5'd6, 16'd140);
    prog[13] = enc_r(5'd3, 5'd1, 5'd9, 6'b101010);
    prog[14] = enc_i(6'd43, 5'd0, 5'd9, 16'd144);
    prog[15] = enc_r(5'd1, 5'd3, 5'd9, 6'b101010);
    prog[16] = enc_i(6'd43, 5'd0, 5'd9, 16'd148);
    prog[17] = enc_r(5'd1, 5'd2, 5'd0, 6'b100000);
    prog[18] = enc_i(6'd43, 5'd0, 5'd0, 16'd152);
    prog[19] = enc_i(6'd35, 5'd4, 5'd12, 16'hFFFC);
    prog[20] = enc_i(6'd43, 5'd0, 5'd12, 16'd156);
    prog[21] = enc_j(26'd21);
    clear_expect(24);
    for (int k = 0; k < 24; k++) e_pc[k] = (k <= 21) ? 32'(4 * k) : 32'd84;
    t_pc[22] = "R7"; t_pc[23] = "R7";
    expect_store(6,  32'd128, 32'd8,          "R9 preload+add");
    expect_store(8,  32'd132, 32'hFFFF_FFFE,  "R3 sub");
    expect_store(10, 32'd136, 32'h000F_00F0,  "R3 and");
    expect_store(12, 32'd140, 32'h0FFF_0FFF,  "R3 or");
    expect_store(14, 32'd144, 32'd1,          "R3 slt true");
    expect_store(16, 32'd148, 32'd0,          "R3 slt false");
    expect_store(18, 32'd152, 32'd0,          "R8 reg0 write ignored");
    expect_store(20, 32'd156, 32'd3,          "R4 negative offset");
    run_prog(24);
    compare(24);
  endtask

  // R6 R7: branches both ways, forward jump, backward branch
  task automatic test_branch();
    plen = 14;
    prog[0]  = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    prog[1]  = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    prog[2]  = enc_i(6'd4,  5'd1, 5'd2, 16'd5);
    prog[3]  = enc_i(6'd4,  5'd1, 5'd1, 16'd2);
    prog[4]  = enc_i(6'd43, 5'd0, 5'd1, 16'd200);
    prog[5]  = enc_i(6'd43, 5'd0, 5'd1, 16'd204);
    prog[6]  = enc_r(5'd1, 5'd2, 5'd3, 6'b100010);
    prog[7]  = enc_i(6'd43, 5'd0, 5'd3, 16'd208);
    prog[8]  = enc_j(26'd11);
    prog[9]  = enc_i(6'd43, 5'd0, 5'd1, 16'd212);
    prog[10] = enc_i(6'd43, 5'd0, 5'd1, 16'd216);
    prog[11] = enc_i(6'd4,  5'd3, 5'd3, 16'd1);
    prog[12] = enc_i(6'd43, 5'd0, 5'd1, 16'd220);
    prog[13] = enc_i(6'd4,  5'd0, 5'd0, 16'hFFFF);
    clear_expect(11);
    e_pc[0] = 0;  e_pc[1] = 4;  e_pc[2] = 8;  e_pc[3] = 12;
    e_pc[4] = 24; e_pc[5] = 28; e_pc[6] = 32; e_pc[7] = 44;
    e_pc[8] = 52; e_pc[9] = 52; e_pc[10] = 52;
    t_pc[3] = "R6 not taken"; t_pc[4] = "R6 taken";
    t_pc[7] = "R7 jump";      t_pc[8] = "R6 forward";
    t_pc[9] = "R6 backward";  t_pc[10] = "R6 backward";
    for (int k = 0; k < 11; k++) t_st[k] = "R6 skipped store";
    expect_store(5, 32'd208, 32'd2, "R5 store after branch");
    run_prog(11);
    compare(11);
  endtask

  // R4 R5 R1: store via base+offset, read back, then reset mid-run
  task automatic test_mem();
    plen = 8;
    prog[0] = enc_i(6'd35, 5'd0, 5'd1, 16'd0);
    prog[1] = enc_i(6'd35, 5'd0, 5'd2, 16'd4);
    prog[2] = enc_r(5'd1, 5'd2, 5'd4, 6'b100000);
    prog[3] = enc_i(6'd43, 5'd4, 5'd2, 16'd96);
    prog[4] = enc_i(6'd35, 5'd0, 5'd5, 16'd104);
    prog[5] = enc_r(5'd5, 5'd5, 5'd6, 6'b100000);
    prog[6] = enc_i(6'd43, 5'd0, 5'd6, 16'd108);
    prog[7] = enc_j(26'd7);
    clear_expect(9);
    for (int k = 0; k < 9; k++) e_pc[k] = (k <= 7) ? 32'(4 * k) : 32'd28;
    expect_store(3, 32'd104, 32'd3, "R5 base plus offset");
    expect_store(6, 32'd108, 32'd6, "R4 load of stored word");
    run_prog(9);
    compare(9);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run reset pc", pc_o, 32'd0);
    chk("R1 mid-run reset store", {31'd0, st_en_o}, 32'd0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    preload_data();
    test_reset();
    test_alu();
    test_branch();
    test_mem();
    summary();
    $finish;
  end
endmodule